// File: doc/BRIEF.md
# Scaled Fixed-Point System Timestamp Counter

This block keeps a free-running 64-bit timestamp for the timers around it. The count is the integer part of an 88-bit accumulator held in 64.24 fixed-point form. On every cycle where the `tick_i` strobe is high and counting is switched on, the accumulator grows by a programmed step. With scaling on, the step is the 32-bit scale value, read as a number with 24 fraction bits. With scaling off, the step is exactly one whole count. The integer part drives `count_o` without pause.

Software reaches the block through a simple 32-bit memory-mapped port with two register frames. `bus_frame` picks the frame: 0 for control, 1 for status. The control frame carries the mode bits, the count halves (read and write), the scale value, a capability word and identification bytes. The status frame is read-only. It gives the live count and its own identification bytes. Read data is combinational and valid in the same cycle as a read request. A write takes effect at the clock edge that samples it.

Top module: `sysstamp_ctr`

## Requirements
- R1: After reset the mode register reads 0, the scale value reads 0x01000000, and the count reads 0 both on `count_o` and through the bus.
- R2: While the enable bit (mode bit 0) is clear, the count does not change unless it is loaded.
- R3: With enable set and scale-enable (mode bit 2) clear, each cycle with `tick_i` high adds exactly 1 to the count, whatever the scale value.
- R4: With enable and scale-enable set, each tick adds the scale value to the 88-bit accumulator, and the count is its upper 64 bits. A scale of 0x00800000 advances the count once every two ticks.
- R5: A cycle with `tick_i` low never advances the count.
- R6: The control-frame mode register at offset 0x0 stores bits [4:0] as written. Bits [31:5] read as zero and ignore writes.
- R7: Offsets 0x8 (low half) and 0xC (high half) of the control frame read the count and write one half of it. The other half keeps its current value, and the 24 fraction bits are cleared. A load wins over a tick in the same cycle.
- R8: The scale value reads and writes at both 0x10 and 0xD0, which hold the same register. Offset 0xD4 reads zero and ignores writes. Offset 0x4 of the control frame always reads zero.
- R9: Control offset 0x1C is read-only and reads 0x00020001.
- R10: The status frame reads the live count at 0x0 (low half) and 0x4 (high half). Any write to the status frame has no effect.
- R11: Offsets 0xFD0 to 0xFFC in both frames are read-only bytes in bits [7:0]: 04,00,00,00,xx,B0,0B,00,0D,F0,05,B1 in address order. xx, at 0xFE0, is 0xBA in the control frame and 0xBB in the status frame.
- R12: A read of any other offset returns zero. A write to any other offset, or to a read-only offset, changes neither the mode, the scale nor the count.
- R13: The accumulator wraps modulo 2^88 with no flag. A count of all ones plus one tick gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe, one step per high cycle |
| bus_req | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_frame | input | 1 | 0 selects the control frame, 1 the status frame |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| count_o | output | 64 | Integer part of the accumulator |

## Verification
The bench builds the block with its default parameters: 32-bit data words, a 64-bit count, 24 fraction bits and a 32-bit scale. This reaches the full 88-bit carry path, including wrap from all ones back to zero. Fractional scales of one half and one and a half show that the fraction carries into the count between ticks. A half load made just after a half-count fraction shows that the fraction bits are cleared.

// File: rtl/sysstamp_pkg.sv
package sysstamp_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_MODE    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_SCALE_A = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CAPS    = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_SCALE_B = 12'h0D0;
  localparam logic [ADDR_W-1:0] OFS_SCALE_X = 12'h0D4;
  localparam logic [ADDR_W-1:0] OFS_IDBASE  = 12'hFD0;

  localparam logic [ADDR_W-1:0] OFS_VIEW_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_VIEW_HI = 12'h004;

  localparam int MODE_W   = 5;
  localparam int MODE_EN  = 0;
  localparam int MODE_SCL = 2;

  localparam logic [31:0] CAPS_WORD = 32'h0002_0001;

  // identification byte for slot idx (0..11 from 0xFD0), per frame
  function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic view);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = view ? 8'hBB : 8'hBA;
      4'd5:    b = 8'hB0;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/sysstamp_accum.sv
module sysstamp_accum #(
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                en_i,
  input  logic                scen_i,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic [DATA_W-1:0]   ld_data_i,
  output logic [2*DATA_W-1:0] count_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int ACC_W = CNT_W + FRAC_W;
  localparam int HALVES = 2;

  logic [ACC_W-1:0]  acc_q, acc_d, step;
  logic [CNT_W-1:0]  cnt, cnt_ld;
  logic [HALVES-1:0] ld_sel;
  logic              ld_any, adv, upd;

  assign cnt    = acc_q[ACC_W-1:FRAC_W];
  assign ld_sel = {ld_hi_i, ld_lo_i};
  assign ld_any = |ld_sel;
  assign adv    = en_i & tick_i;
  assign upd    = ld_any | adv;

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign cnt_ld[h*DATA_W +: DATA_W] = ld_sel[h] ? ld_data_i : cnt[h*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    step = scen_i ? ACC_W'(scale_i) : (ACC_W'(1) << FRAC_W);
  end

  always_comb begin
    acc_d = acc_q;
    if (ld_any) begin
      acc_d = {cnt_ld, {FRAC_W{1'b0}}};
    end else if (adv) begin
      acc_d = acc_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (upd) begin
      acc_q <= acc_d;
    end
  end

  assign count_o = cnt;
endmodule

// File: rtl/sysstamp_cfg_regs.sv
module sysstamp_cfg_regs
  import sysstamp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mode_i,
  input  logic               wr_scale_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic [SCALE_W-1:0] scale_o
);
  localparam logic [SCALE_W-1:0] SCALE_RST = SCALE_W'(1) << FRAC_W;

  logic [MODE_W-1:0]  mode_q, mode_d;
  logic [SCALE_W-1:0] scale_q, scale_d;

  always_comb begin
    mode_d  = wdata_i[MODE_W-1:0];
    scale_d = SCALE_W'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode_i) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= SCALE_RST;
    end else if (wr_scale_i) begin
      scale_q <= scale_d;
    end
  end

  assign mode_o  = mode_q;
  assign scale_o = scale_q;
endmodule

// File: rtl/sysstamp_rd_mux.sv
module sysstamp_rd_mux
  import sysstamp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32
) (
  input  logic                rd_i,
  input  logic                view_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [SCALE_W-1:0]  scale_i,
  input  logic [2*DATA_W-1:0] count_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic       in_id;
  logic [3:0] id_idx;
  logic [DATA_W-1:0] lo_w, hi_w;

  assign lo_w   = count_i[DATA_W-1:0];
  assign hi_w   = count_i[2*DATA_W-1:DATA_W];
  assign in_id  = (addr_i >= OFS_IDBASE) && (addr_i[1:0] == 2'b00);
  assign id_idx = addr_i[5:2] - 4'd4;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (in_id) begin
        rdata_o = DATA_W'(id_byte(id_idx, view_i));
      end else if (!view_i) begin
        case (addr_i)
          OFS_MODE:    rdata_o = DATA_W'(mode_i);
          OFS_CNT_LO:  rdata_o = lo_w;
          OFS_CNT_HI:  rdata_o = hi_w;
          OFS_SCALE_A,
          OFS_SCALE_B: rdata_o = DATA_W'(scale_i);
          OFS_CAPS:    rdata_o = DATA_W'(CAPS_WORD);
          default:     rdata_o = '0;
        endcase
      end else begin
        case (addr_i)
          OFS_VIEW_LO: rdata_o = lo_w;
          OFS_VIEW_HI: rdata_o = hi_w;
          default:     rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysstamp_ctr.sv
module sysstamp_ctr
  import sysstamp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                bus_req,
  input  logic                bus_wr,
  input  logic                bus_frame,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [2*DATA_W-1:0] count_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               wr_ctl, wr_mode, wr_scale, ld_lo, ld_hi, rd_en;
  logic [MODE_W-1:0]  mode_q;
  logic [SCALE_W-1:0] scale_q;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_ctl   = bus_req & bus_wr & ~bus_frame;
  assign wr_mode  = wr_ctl & (bus_addr == OFS_MODE);
  assign wr_scale = wr_ctl & ((bus_addr == OFS_SCALE_A) | (bus_addr == OFS_SCALE_B));
  assign ld_lo    = wr_ctl & (bus_addr == OFS_CNT_LO);
  assign ld_hi    = wr_ctl & (bus_addr == OFS_CNT_HI);
  assign rd_en    = bus_req & ~bus_wr;

  sysstamp_cfg_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_mode_i  (wr_mode),
    .wr_scale_i (wr_scale),
    .wdata_i    (bus_wdata),
    .mode_o     (mode_q),
    .scale_o    (scale_q)
  );

  sysstamp_accum #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (tick_i),
    .en_i      (mode_q[MODE_EN]),
    .scen_i    (mode_q[MODE_SCL]),
    .scale_i   (scale_q),
    .ld_lo_i   (ld_lo),
    .ld_hi_i   (ld_hi),
    .ld_data_i (bus_wdata),
    .count_o   (cnt)
  );

  sysstamp_rd_mux #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_rd (
    .rd_i    (rd_en),
    .view_i  (bus_frame),
    .addr_i  (bus_addr),
    .mode_i  (mode_q),
    .scale_i (scale_q),
    .count_i (cnt),
    .rdata_o (bus_rdata)
  );

  assign count_o = cnt;
endmodule

// File: rtl/sysstamp_ctr_chk.sv
module sysstamp_ctr_chk
  import sysstamp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_i,
  input logic                bus_req,
  input logic                bus_wr,
  input logic                bus_frame,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [2*DATA_W-1:0] count_o,
  input logic                en_q,
  input logic                scen_q
);
  logic c_wr, c_rd, lo_ld, hi_ld, any_ld;
  assign c_wr   = bus_req & bus_wr & ~bus_frame;
  assign c_rd   = bus_req & ~bus_wr & ~bus_frame;
  assign lo_ld  = c_wr & (bus_addr == 12'h008);
  assign hi_ld  = c_wr & (bus_addr == 12'h00C);
  assign any_ld = lo_ld | hi_ld;

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !any_ld) |=> $stable(count_o));

  // R5
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !any_ld) |=> $stable(count_o));

  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !scen_q && tick_i && !any_ld) |=> (count_o == $past(count_o) + 1'b1));

  // R7
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ld |=> (count_o == {$past(count_o[2*DATA_W-1:DATA_W]), $past(bus_wdata)}));

  // R7
  high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ld |=> (count_o == {$past(bus_wdata), $past(count_o[DATA_W-1:0])}));

  // R9
  caps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && bus_addr == 12'h01C) |-> (bus_rdata == 32'h0002_0001));

  // R12
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && bus_addr == 12'h020) |-> (bus_rdata == '0));
endmodule

bind sysstamp_ctr sysstamp_ctr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_frame (bus_frame),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .count_o   (count_o),
  .en_q      (mode_q[MODE_EN]),
  .scen_q    (mode_q[MODE_SCL])
);

// File: tb/sysstamp_ctr_bench.sv
module sysstamp_ctr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        bus_req, bus_wr, bus_frame;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] count_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysstamp_ctr u_sysstamp_ctr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_frame(bus_frame),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_o(count_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic frm, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_frame = frm; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic frm, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_frame = frm; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic read_count(input logic frm, output logic [63:0] c);
    logic [31:0] lo, hi;
    rd(frm, frm ? 12'h000 : 12'h008, lo);
    rd(frm, frm ? 12'h004 : 12'h00C, hi);
    c = {hi, lo};
  endtask

  function automatic logic [7:0] exp_id(input int i, input logic frm);
    case (i)
      0: return 8'h04;
      4: return frm ? 8'hBB : 8'hBA;
      5: return 8'hB0;
      6: return 8'h0B;
      8: return 8'h0D;
      9: return 8'hF0;
      10: return 8'h05;
      11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d; logic [63:0] c;
    rd(0, 12'h000, d); check("R1 mode", d, 0);
    rd(0, 12'h010, d); check("R1 scale", d, 32'h0100_0000);
    read_count(0, c);  check("R1 count bus", c, 0);
    check("R1 count port", count_o, 0);
  endtask

  task automatic t_disabled();
    ticks(5);
    check("R2 disabled hold", count_o, 0);
  endtask

  task automatic t_unscaled();
    logic [63:0] c;
    wr(0, 12'h010, 32'h0040_0000);
    wr(0, 12'h000, 32'h1);
    ticks(7);
    read_count(0, c);
    check("R3 unscaled step", c, 7);
    check("R3 port", count_o, 7);
  endtask

  task automatic t_no_tick();
    repeat (5) @(negedge clk);
    check("R5 no tick", count_o, 7);
  endtask

  task automatic t_mode_bits();
    logic [31:0] d;
    wr(0, 12'h000, 32'hFFFF_FFFF);
    rd(0, 12'h000, d); check("R6 mode mask", d, 32'h1F);
    wr(0, 12'h000, 32'h0000_0012);
    rd(0, 12'h000, d); check("R6 mode value", d, 32'h12);
    wr(0, 12'h000, 32'h0);
  endtask

  task automatic t_scaled();
    logic [31:0] d;
    wr(0, 12'h008, 32'h0);
    wr(0, 12'h00C, 32'h0);
    wr(0, 12'h0D0, 32'h0080_0000);
    rd(0, 12'h010, d); check("R8 scale alias", d, 32'h0080_0000);
    wr(0, 12'h000, 32'h5);
    ticks(5);
    check("R4 half scale 5 ticks", count_o, 2);
    ticks(1);
    check("R4 half scale 6 ticks", count_o, 3);
    wr(0, 12'h010, 32'h0180_0000);
    ticks(3);
    check("R4 scale 1.5", count_o, 7);
  endtask

  task automatic t_halves();
    logic [63:0] c;
    wr(0, 12'h000, 32'h4);
    wr(0, 12'h010, 32'h0080_0000);
    wr(0, 12'h00C, 32'h1234_5678);
    check("R7 high load", count_o, 64'h1234_5678_0000_0007);
    wr(0, 12'h008, 32'hABCD_EF01);
    read_count(1, c);
    check("R10 status view", c, 64'h1234_5678_ABCD_EF01);
    wr(0, 12'h000, 32'h5);
    ticks(1);
    check("R7 fraction cleared", count_o, 64'h1234_5678_ABCD_EF01);
    wr(0, 12'h000, 32'h1);
    @(negedge clk);
    tick_i = 1; bus_req = 1; bus_wr = 1; bus_frame = 0;
    bus_addr = 12'h008; bus_wdata = 32'h10;
    @(negedge clk);
    tick_i = 0; bus_req = 0; bus_wr = 0;
    check("R7 load over tick", count_o, 64'h1234_5678_0000_0010);
    wr(0, 12'h000, 32'h0);
  endtask

  task automatic t_spare_regs();
    logic [31:0] d;
    wr(0, 12'h0D4, 32'hFFFF_FFFF);
    rd(0, 12'h0D4, d); check("R8 second scale reads zero", d, 0);
    rd(0, 12'h0D0, d); check("R8 scale untouched", d, 32'h0080_0000);
    wr(0, 12'h004, 32'hFFFF_FFFF);
    rd(0, 12'h004, d); check("R8 status word zero", d, 0);
  endtask

  task automatic t_caps();
    logic [31:0] d;
    rd(0, 12'h01C, d); check("R9 caps", d, 32'h0002_0001);
    wr(0, 12'h01C, 32'h0);
    rd(0, 12'h01C, d); check("R9 caps read-only", d, 32'h0002_0001);
  endtask

  task automatic t_idbytes();
    logic [31:0] d;
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 12; i++) begin
        wr(f[0], 12'hFD0 + 12'(i*4), 32'hFF);
        rd(f[0], 12'hFD0 + 12'(i*4), d);
        check($sformatf("R11 id frame%0d slot%0d", f, i), d, {24'h0, exp_id(i, f[0])});
      end
    end
  endtask

  task automatic t_status_wr();
    wr(1, 12'h000, 32'hDEAD_BEEF);
    wr(1, 12'h004, 32'hDEAD_BEEF);
    check("R10 status write ignored", count_o, 64'h1234_5678_0000_0010);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    rd(0, 12'h020, d); check("R12 hole ctl 0x20", d, 0);
    rd(0, 12'h100, d); check("R12 hole ctl 0x100", d, 0);
    rd(1, 12'h008, d); check("R12 hole view 0x8", d, 0);
    wr(0, 12'h020, 32'hFFFF_FFFF);
    wr(0, 12'h0FC, 32'hFFFF_FFFF);
    rd(0, 12'h000, d); check("R12 mode unchanged", d, 0);
    rd(0, 12'h010, d); check("R12 scale unchanged", d, 32'h0080_0000);
    check("R12 count unchanged", count_o, 64'h1234_5678_0000_0010);
  endtask

  task automatic t_wrap();
    wr(0, 12'h008, 32'hFFFF_FFFF);
    wr(0, 12'h00C, 32'hFFFF_FFFF);
    wr(0, 12'h000, 32'h1);
    ticks(1);
    check("R13 wrap to zero", count_o, 0);
    ticks(2);
    check("R13 after wrap", count_o, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick_i = 0; bus_req = 0; bus_wr = 0; bus_frame = 0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_unscaled();
    t_no_tick();
    t_mode_bits();
    t_scaled();
    t_halves();
    t_spare_regs();
    t_caps();
    t_idbytes();
    t_status_wr();
    t_undef();
    t_wrap();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule